// File: doc/BRIEF.md
# Buffered Five-Channel PWM Timer Bank

The bank holds five down-counting PWM timers behind a small 32-bit register bus made of address, write enable, write data and read data. Each channel has a count buffer and a compare buffer, which software may change at any time. These buffers reach the running counter in only two ways: a manual-update strobe, or an automatic reload when a period ends. A new period or duty setting therefore takes effect cleanly at a boundary and never in the middle of a period.

All five channels take their start, manual-update, output-invert and auto-reload bits from one shared control register. Channel 0 also has a stored dead-zone enable bit. A single-cycle tick enable advances every running counter by one. Each channel drives one registered PWM pin. A sticky status register records the end of each period; software clears a bit by writing 1 to it.

The usual software sequence has three steps:
1. Write both buffers.
2. Pulse the manual-update bit while start is clear.
3. Set start together with auto-reload.

A channel whose auto-reload is clear runs one final period and then halts.

Top module: `pwm_bank`

## Requirements
- R1: After reset, the following are all zero:
  - every buffer, counter, compare, configuration and control bit;
  - the status register;
  - every read of them;
  - every PWM pin.
- R2: Addresses 0x00 and 0x04 are 32-bit read/write storage words. For channel n, the count buffer is at 0x0C+12n and the compare buffer is at 0x10+12n; both are read/write. Read data appears on the clock edge after the address is presented.
- R3: The control register is at 0x08. Channel n's field starts at bit 0 for n=0 and at bit 4(n+1) for n≥1. Within a field the offsets are:
  - +0 start;
  - +1 manual update;
  - +2 invert;
  - +3 auto-reload.

  Channel 0 alone also has a stored dead-zone bit at bit 4. Every other control bit reads as zero, so writing all ones reads back 0x00FFFF1F.
- R4: On every clock where a channel's manual-update bit is set, the channel copies both buffers into its active counter and its active compare, and it does not count. Writing a buffer without an update leaves the active counter unchanged.
- R5: A started channel decrements its counter by one on each tick. The live count can be read at 0x14+12n for channels 0 to 3 and at 0x48 for channel 4. Writes to these observation addresses are ignored.
- R6: A count-buffer value of N−1 gives a period of N ticks. When a tick arrives at count 0 with auto-reload set, the channel reloads both its counter and its compare from the buffers.
- R7: When a tick arrives at count 0 with auto-reload clear, the channel halts with its counter at 0. It then counts no further and produces no further period-end events until a manual update rearms it.
- R8: Before inversion, the pin is high while the channel is started, not halted, and its count is at or below its compare value. In every other case the pin is low. The pin follows the counter with one clock of delay.
- R9: The invert bit flips the pin, including its idle level.
- R10: Status bit n at 0x44 is set by a tick at count 0 on a running channel. Writing 1 to the bit clears it, and writing 0 leaves it unchanged. If a set and a clear happen in the same clock, the set wins.
- R11: Unmapped addresses read as zero and ignore writes. This includes unaligned addresses and addresses beyond 0x48.
- R12: Each channel counts only from its own control field and its own buffers; the other channels have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse shared by all channels |
| addr | input | ADDR_W (8) | Register byte address |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous address |
| pwm_o | output | NCH (5) | One PWM pin per channel, bit n for channel n |

## Verification
The assertions check these behaviours on every cycle:
- the manual update loads the active registers;
- a running channel decrements by exactly one per tick, and a channel with no tick holds its count;
- the counter reloads at the end of a period;
- a halted channel stays frozen;
- the pin idles at the invert level;
- status bits are sticky;
- unmapped reads return zero.

Only the bench scenarios can show how these behaviours combine in practice:
- the packed control-field positions;
- the period length and duty;
- mid-period buffer writes taking effect at the next boundary;
- the halt and rearm sequence;
- the relocated observation address of the last channel;
- independence between channels.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int ADR_CFG_A = 'h00;
  localparam int ADR_CFG_B = 'h04;
  localparam int ADR_CTRL  = 'h08;
  localparam int ADR_STAT  = 'h44;
  localparam int ADR_SPILL = 'h48;  // observation slot that would fall on status moves here

  localparam int OFS_START = 0;
  localparam int OFS_UPD   = 1;
  localparam int OFS_INV   = 2;
  localparam int OFS_AR    = 3;
  localparam int BIT_DZ0   = 4;

  typedef struct packed {
    logic start;
    logic upd;
    logic inv;
    logic ar;
  } chan_ctl_t;

  function automatic int fld_base(input int n);
    return (n == 0) ? 0 : 4 * (n + 1);
  endfunction

  function automatic logic [31:0] ctrl_mask(input int nch);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < nch; i++) begin
      for (int k = 0; k < 4; k++) m[fld_base(i) + k] = 1'b1;
    end
    m[BIT_DZ0] = 1'b1;
    return m;
  endfunction

  function automatic int cntb_addr(input int n);
    return 'h0C + 12 * n;
  endfunction

  function automatic int cmpb_addr(input int n);
    return 'h10 + 12 * n;
  endfunction

  function automatic int obs_addr(input int n);
    int a;
    a = 'h14 + 12 * n;
    return (a == ADR_STAT) ? ADR_SPILL : a;
  endfunction

endpackage

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  chan_ctl_t        ctl,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt_o,
  output logic             end_o,
  output logic             pwm_o
);

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             halt_q, pwm_q;
  logic             active, run;

  assign active = ctl.start & ~halt_q;
  assign run    = active & ~ctl.upd;
  assign end_o  = run & tick & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      cmp_q  <= '0;
      halt_q <= 1'b0;
      pwm_q  <= 1'b0;
    end else begin
      if (ctl.upd) begin
        cnt_q  <= cnt_buf;
        cmp_q  <= cmp_buf;
        halt_q <= 1'b0;
      end else if (run && tick) begin
        if (cnt_q == '0) begin
          if (ctl.ar) begin
            cnt_q <= cnt_buf;
            cmp_q <= cmp_buf;
          end else begin
            halt_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
      pwm_q <= (active & (cnt_q <= cmp_q)) ^ ctl.inv;
    end
  end

  assign cnt_o = cnt_q;
  assign pwm_o = pwm_q;

  assert_upd_load_R4: assert property (@(posedge clk) disable iff (rst)
    ctl.upd |=> (cnt_q == $past(cnt_buf)) && (cmp_q == $past(cmp_buf)));

  assert_dec_R5: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctl.upd && !(run && tick)) |=> $stable(cnt_q));

  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (end_o && ctl.ar) |=> cnt_q == $past(cnt_buf));

  assert_halt_R7: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !ctl.upd) |=> $stable(cnt_q));

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !active |=> pwm_q == $past(ctl.inv));

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       we,
  input  logic [31:0]                wdata,
  input  logic [NCH-1:0]             end_i,
  input  logic [NCH-1:0][CNT_W-1:0]  cnt_i,
  output chan_ctl_t [NCH-1:0]        ctl_o,
  output logic [NCH-1:0][CNT_W-1:0]  cntb_o,
  output logic [NCH-1:0][CNT_W-1:0]  cmpb_o,
  output logic [31:0]                rdata
);

  localparam logic [31:0] CTRL_MASK = ctrl_mask(NCH);

  logic [31:0]               cfg_a_q, cfg_b_q, ctrl_q, rd_q, rd_d;
  logic [NCH-1:0]            stat_q, stat_clr;
  logic [NCH-1:0][CNT_W-1:0] cntb_q, cmpb_q;
  logic                      mapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_a_q <= '0;
      cfg_b_q <= '0;
      ctrl_q  <= '0;
      cntb_q  <= '0;
      cmpb_q  <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(ADR_CFG_A)) cfg_a_q <= wdata;
      if (addr == ADDR_W'(ADR_CFG_B)) cfg_b_q <= wdata;
      if (addr == ADDR_W'(ADR_CTRL))  ctrl_q  <= wdata & CTRL_MASK;
      for (int n = 0; n < NCH; n++) begin
        if (addr == ADDR_W'(cntb_addr(n))) cntb_q[n] <= wdata[CNT_W-1:0];
        if (addr == ADDR_W'(cmpb_addr(n))) cmpb_q[n] <= wdata[CNT_W-1:0];
      end
    end
  end

  assign stat_clr = (we && addr == ADDR_W'(ADR_STAT)) ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~stat_clr) | end_i;
  end

  always_comb begin
    rd_d   = '0;
    mapped = 1'b0;
    if (addr == ADDR_W'(ADR_CFG_A)) begin rd_d = cfg_a_q; mapped = 1'b1; end
    if (addr == ADDR_W'(ADR_CFG_B)) begin rd_d = cfg_b_q; mapped = 1'b1; end
    if (addr == ADDR_W'(ADR_CTRL))  begin rd_d = ctrl_q;  mapped = 1'b1; end
    if (addr == ADDR_W'(ADR_STAT))  begin rd_d = 32'(stat_q); mapped = 1'b1; end
    for (int n = 0; n < NCH; n++) begin
      if (addr == ADDR_W'(cntb_addr(n))) begin rd_d = 32'(cntb_q[n]); mapped = 1'b1; end
      if (addr == ADDR_W'(cmpb_addr(n))) begin rd_d = 32'(cmpb_q[n]); mapped = 1'b1; end
      if (addr == ADDR_W'(obs_addr(n)))  begin rd_d = 32'(cnt_i[n]);  mapped = 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ctl
    assign ctl_o[g].start = ctrl_q[fld_base(g) + OFS_START];
    assign ctl_o[g].upd   = ctrl_q[fld_base(g) + OFS_UPD];
    assign ctl_o[g].inv   = ctrl_q[fld_base(g) + OFS_INV];
    assign ctl_o[g].ar    = ctrl_q[fld_base(g) + OFS_AR];
  end

  assign cntb_o = cntb_q;
  assign cmpb_o = cmpb_q;
  assign rdata  = rd_q;

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> rd_q == '0);

  assert_stat_set_R10: assert property (@(posedge clk) disable iff (rst)
    (|end_i) |=> (stat_q & $past(end_i)) == $past(end_i));

  assert_stat_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == ADDR_W'(ADR_STAT)) |=> (stat_q & $past(stat_q)) == $past(stat_q));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 5,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_o
);

  chan_ctl_t [NCH-1:0]       ctl;
  logic [NCH-1:0][CNT_W-1:0] cntb, cmpb, cnt;
  logic [NCH-1:0]            ends;

  pwm_regs #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .addr   (addr),
    .we     (we),
    .wdata  (wdata),
    .end_i  (ends),
    .cnt_i  (cnt),
    .ctl_o  (ctl),
    .cntb_o (cntb),
    .cmpb_o (cmpb),
    .rdata  (rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .ctl     (ctl[g]),
      .cnt_buf (cntb[g]),
      .cmp_buf (cmpb[g]),
      .cnt_o   (cnt[g]),
      .end_o   (ends[g]),
      .pwm_o   (pwm_o[g])
    );
  end

endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  pwm;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    bit          is_pin;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];

  pwm_bank u_pwm_bank (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr), .we(we),
    .wdata(wdata), .rdata(rdata), .pwm_o(pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected items and compares away from the rising edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = it.is_pin ? 32'(pwm) : rdata;
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a;
    @(posedge clk); #1;
    sb.push_back('{1'b0, e, tag});
    @(negedge clk);
  endtask

  task automatic pin(input logic [4:0] e, input string tag);
    @(posedge clk); #1;
    sb.push_back('{1'b1, 32'(e), tag});
    @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  localparam logic [7:0] CTRL = 8'h08, STAT = 8'h44;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    rd(CTRL, 0, "R1 ctrl after reset");
    rd(8'h14, 0, "R1 count0 after reset");
    rd(STAT, 0, "R1 status after reset");
    pin(5'h00, "R1 pins after reset");
    // storage words and buffers
    wr(8'h00, 32'hA5A5_1234); rd(8'h00, 32'hA5A5_1234, "R2 cfg word 0");
    wr(8'h04, 32'h0BAD_F00D); rd(8'h04, 32'h0BAD_F00D, "R2 cfg word 1");
    wr(8'h0C, 4); wr(8'h10, 1);
    rd(8'h0C, 4, "R2 count buffer 0");
    rd(8'h10, 1, "R2 compare buffer 0");
    rd(8'h14, 0, "R4 buffer write alone does not load");
    // manual update
    wr(CTRL, 32'h2); rd(8'h14, 4, "R4 update loads counter");
    step(); rd(8'h14, 4, "R4 no count while updating");
    // run with auto-reload, N=5 cmp=1
    wr(CTRL, 32'h9); pin(5'h00, "R8 low above compare");
    step(); rd(8'h14, 3, "R5 decrement per tick");
    step(); pin(5'h00, "R8 low at 2");
    step(); pin(5'h01, "R8 high at compare");
    rd(STAT, 0, "R10 no status mid period");
    step(); pin(5'h01, "R8 high at 0");
    step(); rd(8'h14, 4, "R6 reload after 5 ticks");
    rd(STAT, 1, "R10 status set at period end");
    pin(5'h00, "R8 low after reload");
    wr(STAT, 0); rd(STAT, 1, "R10 write 0 keeps status");
    wr(STAT, 1); rd(STAT, 0, "R10 write 1 clears status");
    // mid-period buffer change
    wr(8'h0C, 2); wr(8'h10, 0);
    rd(8'h14, 4, "R4 mid period write not applied");
    repeat (4) step();
    pin(5'h01, "R6 old compare kept to period end");
    step(); rd(8'h14, 2, "R6 reload takes new count");
    pin(5'h00, "R6 reload takes new compare");
    step(); step();
    pin(5'h01, "R8 high at 0 new period");
    step(); rd(8'h14, 2, "R6 period of 3 ticks");
    // invert
    wr(CTRL, 32'hD); pin(5'h01, "R9 inverted low phase");
    step(); step(); pin(5'h00, "R9 inverted high phase");
    // no auto-reload: halt
    wr(STAT, 1); wr(CTRL, 32'h1);
    step();
    rd(STAT, 1, "R7 final period end flagged");
    rd(8'h14, 0, "R7 halted at zero");
    pin(5'h00, "R8 idle low when halted");
    wr(STAT, 1); step(); step();
    rd(STAT, 0, "R7 no events while halted");
    rd(8'h14, 0, "R7 count frozen");
    wr(CTRL, 32'h2); wr(CTRL, 32'h1); step();
    rd(8'h14, 1, "R7 update rearms channel");
    // idle invert
    wr(CTRL, 32'h4); pin(5'h01, "R9 idle level inverted");
    // control mask
    wr(CTRL, 32'hFFFF_FFFF); rd(CTRL, 32'h00FF_FF1F, "R3 control readback mask");
    wr(CTRL, 0);
    // channel 3 field at bit 16
    wr(8'h30, 3); wr(8'h34, 3);
    wr(CTRL, 32'h0002_0000); rd(8'h38, 3, "R3 channel 3 update bit 17");
    wr(CTRL, 32'h0001_0000); pin(5'h08, "R12 only channel 3 drives");
    step(); rd(8'h38, 2, "R12 channel 3 counts");
    rd(8'h14, 2, "R12 channel 0 untouched");
    // channel 4 observation at 0x48
    wr(8'h3C, 7); wr(CTRL, 32'h0020_0000);
    rd(8'h48, 7, "R5 channel 4 count at 0x48");
    // ignored writes and unmapped reads
    wr(8'h14, 32'h55); rd(8'h14, 2, "R5 observation write ignored");
    wr(8'h4C, 32'hFFFF); rd(8'h4C, 0, "R11 unmapped reads zero");
    rd(8'h01, 0, "R11 unaligned reads zero");
    done = 1;
    @(negedge clk); @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule